// File: doc/BRIEF.md
# Inter-Core Interrupt Hub

This block is shared by a cluster of cores and lets any core raise an interrupt on any other core. Each core has its own command port: a valid strobe, a two-bit opcode and a core-number operand, plus a readback register that holds the answer to status and source queries. Inside, the hub keeps a square matrix of pending bits, one for every ordered pair of sender and receiver. A core's interrupt line is the OR of every pending bit aimed at it.

A receiving core that sees its line go high asks the hub which cores signalled it. The answer is a mask with one bit per sender. Several senders can be merged onto one asserted line, so the receiver acknowledges each sender in the mask with its own command. A sender can ask whether its earlier interrupt to a given target is still unacknowledged before it raises another one. When several cores issue commands in the same cycle, a rotating-priority arbiter accepts one of them per cycle and returns a ready to that core only.

Top module: `ipi_hub`

## Requirements
- R1: Reset (synchronous, active low) clears every pending bit and every readback register, so all interrupt lines and all readback values are zero after reset.
- R2: A raise command (opcode 1) accepted from core i with operand t, where t differs from i, sets the pending bit from i to t. Line irq[t] is high from the cycle after acceptance.
- R3: A raise command whose operand equals the issuing core changes no pending bit and no interrupt line.
- R4: A status command (opcode 0) from core i with operand t loads core i's readback with value 1 if the pending bit from i to t is set, and with 0 otherwise. The value is visible the cycle after acceptance.
- R5: A source query (opcode 2) from core i loads core i's readback with a mask in which bit s is 1 exactly when the pending bit from core s to core i is set.
- R6: When several cores have raised the same target, that target's single line is high and its source-query mask has one bit set for each of those senders. This includes raises issued by different cores in the same cycle.
- R7: An acknowledge (opcode 3) from core i with operand c clears only the pending bit from c to i. Line irq[i] stays high until every sender in its mask has been acknowledged, and an acknowledge never raises any line.
- R8: Raising a target that already has a pending bit from the same sender leaves that bit set without counting a second event, so one acknowledge clears it.
- R9: At most one ready is high per cycle, and only to a core with valid high. A command is held until its ready is seen. After reset, core 0 has top priority. After a grant to core k, priority starts at core k+1, wrapping from the last core to core 0.
- R10: Raise and acknowledge commands leave the issuer's readback register unchanged. Only status and source-query commands write it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | NUM_CORES | Per-core command request, held until ready |
| cmd_op | input | 2*NUM_CORES | Per-core opcode: 0 status, 1 raise, 2 source query, 3 acknowledge |
| cmd_core | input | ID_W*NUM_CORES | Per-core operand core number |
| cmd_ready | output | NUM_CORES | Per-core acceptance, one-hot or zero |
| rb_data | output | NUM_CORES*NUM_CORES | Per-core readback register, NUM_CORES bits each |
| irq | output | NUM_CORES | Per-core interrupt line |

## Verification
The hardest state to reach is a merged line: one receiver with several senders pending, including two raises that contend in the same cycle and are serialised by the arbiter. The bench builds this in two ways. It issues raises from three cores in turn, and it presents raises from two cores at once. It then acknowledges the senders one at a time and checks after each step that the line holds and the mask shrinks. The rotation of priority is checked by presenting overlapping request sets and recording the order in which ready returns.

// File: rtl/ipi_pkg.sv
// Shared types for the inter-core interrupt hub.
package ipi_pkg;
    // Command opcodes presented on each core's port
    typedef enum logic [1:0] {
        OP_STATUS = 2'd0,
        OP_RAISE  = 2'd1,
        OP_WHO    = 2'd2,
        OP_ACK    = 2'd3
    } ipi_op_e;
endpackage

// File: rtl/ipi_rr_arbiter.sv
// Rotating-priority arbiter: grants one requester per cycle, starting the
// search at the core after the last one granted. Assumes NUM_CORES >= 2.
module ipi_rr_arbiter #(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = $clog2(NUM_CORES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] req,
    output logic [NUM_CORES-1:0] grant,
    output logic                 grant_valid,
    output logic [ID_W-1:0]      grant_idx
);
    localparam logic [ID_W-1:0] LAST = ID_W'(NUM_CORES - 1);

    logic [ID_W-1:0] prio_q;

    // Pick the first requester at or after the priority pointer
    always_comb begin
        int idx;
        grant       = '0;
        grant_valid = 1'b0;
        grant_idx   = '0;
        idx         = 0;
        for (int off = 0; off < NUM_CORES; off++) begin
            idx = (int'(prio_q) + off) % NUM_CORES;
            if (!grant_valid && req[idx]) begin
                grant_valid = 1'b1;
                grant[idx]  = 1'b1;
                grant_idx   = ID_W'(idx);
            end
        end
    end

    // Move priority to the core after the one just granted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (grant_valid) begin
            prio_q <= (grant_idx == LAST) ? '0 : grant_idx + 1'b1;
        end
    end
endmodule

// File: rtl/ipi_cmd_decode.sv
// Decodes the granted core's command into one matrix update and/or one
// readback write. Assumes at most one command is granted per cycle.
module ipi_cmd_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = $clog2(NUM_CORES)
) (
    input  logic                   grant_valid,
    input  logic [ID_W-1:0]        grant_idx,
    input  logic [2*NUM_CORES-1:0] op_bus,
    input  logic [ID_W*NUM_CORES-1:0] core_bus,
    output logic                   upd_valid,
    output logic                   upd_set,
    output logic [ID_W-1:0]        upd_src,
    output logic [ID_W-1:0]        upd_dst,
    output logic                   rb_wr,
    output logic                   rb_who,
    output logic [ID_W-1:0]        rb_core,
    output logic [ID_W-1:0]        rb_target
);
    ipi_op_e         op;
    logic [ID_W-1:0] tgt;
    logic            tgt_ok;

    // Select the granted core's opcode and operand
    always_comb begin
        op     = ipi_op_e'(op_bus[int'(grant_idx)*2 +: 2]);
        tgt    = core_bus[int'(grant_idx)*ID_W +: ID_W];
        tgt_ok = int'(tgt) < NUM_CORES;
    end

    // Turn the opcode into matrix and readback actions
    always_comb begin
        upd_valid = 1'b0;
        upd_set   = 1'b0;
        upd_src   = grant_idx;
        upd_dst   = tgt;
        rb_wr     = 1'b0;
        rb_who    = 1'b0;
        rb_core   = grant_idx;
        rb_target = tgt;
        if (grant_valid) begin
            unique case (op)
                OP_STATUS: rb_wr = 1'b1;
                OP_WHO: begin
                    rb_wr  = 1'b1;
                    rb_who = 1'b1;
                end
                OP_RAISE: begin
                    upd_valid = tgt_ok && (tgt != grant_idx);
                    upd_set   = 1'b1;
                    upd_src   = grant_idx;
                    upd_dst   = tgt;
                end
                OP_ACK: begin
                    upd_valid = tgt_ok;
                    upd_set   = 1'b0;
                    upd_src   = tgt;
                    upd_dst   = grant_idx;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ipi_pending_matrix.sv
// Sender-by-receiver pending bits; bit s*N+r means core s has an
// unacknowledged interrupt toward core r. Drives one line per receiver.
module ipi_pending_matrix #(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = $clog2(NUM_CORES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           upd_valid,
    input  logic                           upd_set,
    input  logic [ID_W-1:0]                upd_src,
    input  logic [ID_W-1:0]                upd_dst,
    output logic [NUM_CORES*NUM_CORES-1:0] pend,
    output logic [NUM_CORES-1:0]           irq
);
    // Apply the single set or clear for this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (upd_valid) begin
            pend[int'(upd_src)*NUM_CORES + int'(upd_dst)] <= upd_set;
        end
    end

    // OR each receiver's column into its interrupt line
    always_comb begin
        irq = '0;
        for (int s = 0; s < NUM_CORES; s++) begin
            for (int r = 0; r < NUM_CORES; r++) begin
                irq[r] = irq[r] | pend[s*NUM_CORES + r];
            end
        end
    end
endmodule

// File: rtl/ipi_readback.sv
// Per-core readback registers. A status write stores the single pending
// bit issuer->target in bit 0; a source query stores the issuer's column.
module ipi_readback #(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = $clog2(NUM_CORES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rb_wr,
    input  logic                           rb_who,
    input  logic [ID_W-1:0]                rb_core,
    input  logic [ID_W-1:0]                rb_target,
    input  logic [NUM_CORES*NUM_CORES-1:0] pend,
    output logic [NUM_CORES*NUM_CORES-1:0] rb_data
);
    logic [NUM_CORES-1:0] value;

    // Form the answer from the matrix as it stands before this edge
    always_comb begin
        value = '0;
        if (rb_who) begin
            for (int s = 0; s < NUM_CORES; s++) begin
                value[s] = pend[s*NUM_CORES + int'(rb_core)];
            end
        end else if (int'(rb_target) < NUM_CORES) begin
            value[0] = pend[int'(rb_core)*NUM_CORES + int'(rb_target)];
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_rb
        // Load this core's register when its query is served
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rb_data[c*NUM_CORES +: NUM_CORES] <= '0;
            end else if (rb_wr && rb_core == ID_W'(c)) begin
                rb_data[c*NUM_CORES +: NUM_CORES] <= value;
            end
        end
    end
endmodule

// File: rtl/ipi_hub.sv
// Top of the inter-core interrupt hub: arbiter, decoder, pending matrix
// and readback. Commands are held by each core until its ready is seen.
module ipi_hub
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = $clog2(NUM_CORES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CORES-1:0]           cmd_valid,
    input  logic [2*NUM_CORES-1:0]         cmd_op,
    input  logic [ID_W*NUM_CORES-1:0]      cmd_core,
    output logic [NUM_CORES-1:0]           cmd_ready,
    output logic [NUM_CORES*NUM_CORES-1:0] rb_data,
    output logic [NUM_CORES-1:0]           irq
);
    logic                           gnt_valid;
    logic [ID_W-1:0]                gnt_idx;
    logic                           upd_valid;
    logic                           upd_set;
    logic [ID_W-1:0]                upd_src;
    logic [ID_W-1:0]                upd_dst;
    logic                           rb_wr;
    logic                           rb_who;
    logic [ID_W-1:0]                rb_core;
    logic [ID_W-1:0]                rb_target;
    logic [NUM_CORES*NUM_CORES-1:0] pend;

    ipi_rr_arbiter #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) i_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (cmd_valid),
        .grant       (cmd_ready),
        .grant_valid (gnt_valid),
        .grant_idx   (gnt_idx)
    );

    ipi_cmd_decode #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) i_dec (
        .grant_valid (gnt_valid),
        .grant_idx   (gnt_idx),
        .op_bus      (cmd_op),
        .core_bus    (cmd_core),
        .upd_valid   (upd_valid),
        .upd_set     (upd_set),
        .upd_src     (upd_src),
        .upd_dst     (upd_dst),
        .rb_wr       (rb_wr),
        .rb_who      (rb_who),
        .rb_core     (rb_core),
        .rb_target   (rb_target)
    );

    ipi_pending_matrix #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) i_mat (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_set   (upd_set),
        .upd_src   (upd_src),
        .upd_dst   (upd_dst),
        .pend      (pend),
        .irq       (irq)
    );

    ipi_readback #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) i_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rb_wr     (rb_wr),
        .rb_who    (rb_who),
        .rb_core   (rb_core),
        .rb_target (rb_target),
        .pend      (pend),
        .rb_data   (rb_data)
    );
endmodule

// File: rtl/ipi_hub_chk.sv
// Port-level properties of the interrupt hub, bound into every instance.
module ipi_hub_chk
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = $clog2(NUM_CORES)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CORES-1:0]      cmd_valid,
    input logic [2*NUM_CORES-1:0]    cmd_op,
    input logic [ID_W*NUM_CORES-1:0] cmd_core,
    input logic [NUM_CORES-1:0]      cmd_ready,
    input logic [NUM_CORES-1:0]      irq
);
    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_ready));

    // R9
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready & ~cmd_valid) == '0);

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        logic [1:0]      op_i;
        logic [ID_W-1:0] tg_i;
        assign op_i = cmd_op[i*2 +: 2];
        assign tg_i = cmd_core[i*ID_W +: ID_W];

        // R3
        self_raise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_ready[i] && op_i == OP_RAISE && tg_i == ID_W'(i)) |=> $stable(irq));

        // R7
        ack_never_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_ready[i] && op_i == OP_ACK) |=> ((irq & ~$past(irq)) == '0));

        for (genvar t = 0; t < NUM_CORES; t++) begin : g_tgt
            if (t != i) begin : g_other
                // R2
                raise_sets_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (cmd_ready[i] && op_i == OP_RAISE && tg_i == ID_W'(t)) |=> irq[t]);
            end
        end
    end
endmodule

bind ipi_hub ipi_hub_chk #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) i_ipi_hub_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_core  (cmd_core),
    .cmd_ready (cmd_ready),
    .irq       (irq)
);

// File: tb/test_ipi_hub.sv
// Directed bench for the interrupt hub; each task checks its own scenario.
module test_ipi_hub;
    localparam int N   = 4;
    localparam int IDW = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     cmd_valid = '0;
    logic [2*N-1:0]   cmd_op = '0;
    logic [IDW*N-1:0] cmd_core = '0;
    logic [N-1:0]     cmd_ready;
    logic [N*N-1:0]   rb_data;
    logic [N-1:0]     irq;

    int n_checks = 0;
    int n_fail   = 0;
    int glog[0:N-1];
    int glog_n;

    always #4 clk = ~clk;

    ipi_hub #(.NUM_CORES(N), .ID_W(IDW)) i_ipi_hub (
        .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_core, .cmd_ready, .rb_data, .irq
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int rb(input int c);
        return int'(rb_data[c*N +: N]);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one command on core c and wait until it is accepted
    task automatic issue(input int c, input int op, input int tgt);
        cmd_valid[c] = 1'b1;
        cmd_op[c*2 +: 2] = 2'(op);
        cmd_core[c*IDW +: IDW] = IDW'(tgt);
        #1;
        while (!cmd_ready[c]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        cmd_valid[c] = 1'b0;
    endtask

    // Present several cores at once and log the grant order
    task automatic batch(input logic [N-1:0] mask, input int op, input int tgt);
        glog_n = 0;
        for (int c = 0; c < N; c++) begin
            if (mask[c]) begin
                cmd_op[c*2 +: 2] = 2'(op);
                cmd_core[c*IDW +: IDW] = IDW'(tgt);
            end
        end
        cmd_valid = mask;
        while (cmd_valid != '0) begin
            #1;
            check("R9 ready one-hot", $countones(cmd_ready) <= 1 ? 1 : 0, 1);
            for (int c = 0; c < N; c++) begin
                if (cmd_ready[c]) begin
                    glog[glog_n] = c;
                    glog_n++;
                end
            end
            @(posedge clk);
            @(negedge clk);
            cmd_valid = cmd_valid & ~mask_of_last();
        end
    endtask

    function automatic logic [N-1:0] mask_of_last();
        logic [N-1:0] m = '0;
        if (glog_n > 0) m[glog[glog_n-1]] = 1'b1;
        return m;
    endfunction

    task automatic t_reset();
        do_reset();
        check("R1 irq after reset", int'(irq), 0);
        check("R1 readback after reset", int'(rb_data), 0);
    endtask

    task automatic t_raise();
        issue(0, 1, 2);
        check("R2 line of target", int'(irq), 'b0100);
        issue(0, 0, 2);
        check("R4 status pending", rb(0), 1);
        issue(1, 0, 2);
        check("R4 status other sender", rb(1), 0);
        issue(2, 2, 0);
        check("R5 source mask", rb(2), 'b0001);
        issue(2, 3, 0);
        check("R7 ack clears line", int'(irq), 0);
        issue(0, 0, 2);
        check("R4 status after ack", rb(0), 0);
    endtask

    task automatic t_self();
        issue(1, 1, 1);
        check("R3 self raise line", int'(irq), 0);
        issue(1, 2, 0);
        check("R3 self raise mask", rb(1), 0);
    endtask

    task automatic t_merge();
        issue(0, 1, 2);
        issue(1, 1, 2);
        issue(3, 1, 2);
        check("R6 merged line", int'(irq), 'b0100);
        issue(2, 2, 0);
        check("R6 merged mask", rb(2), 'b1011);
        issue(2, 3, 1);
        check("R7 line held", int'(irq), 'b0100);
        issue(2, 2, 0);
        check("R7 only one sender cleared", rb(2), 'b1001);
        issue(2, 3, 0);
        check("R7 line held again", int'(irq), 'b0100);
        issue(2, 3, 3);
        check("R7 line drops", int'(irq), 0);
    endtask

    task automatic t_repeat();
        issue(3, 1, 0);
        issue(3, 1, 0);
        issue(0, 2, 0);
        check("R8 single sender bit", rb(0), 'b1000);
        issue(0, 3, 3);
        check("R8 one ack suffices", int'(irq), 0);
    endtask

    task automatic t_hold();
        issue(1, 1, 2);
        issue(2, 2, 0);
        check("R5 mask before hold", rb(2), 'b0010);
        issue(2, 1, 3);
        check("R10 raise keeps readback", rb(2), 'b0010);
        issue(2, 3, 1);
        check("R10 ack keeps readback", rb(2), 'b0010);
        issue(3, 3, 2);
        check("R7 cleanup", int'(irq), 0);
    endtask

    task automatic t_arb();
        do_reset();
        batch(4'b1111, 0, 0);
        check("R9 count", glog_n, 4);
        for (int k = 0; k < 4; k++) check("R9 order after reset", glog[k], k);
        batch(4'b0101, 0, 0);
        check("R9 order 0 then 2 first", glog[0], 0);
        check("R9 order 0 then 2 second", glog[1], 2);
        batch(4'b1010, 0, 0);
        check("R9 rotate 3 before 1", glog[0], 3);
        check("R9 rotate 1 second", glog[1], 1);
        batch(4'b1001, 1, 1);
        check("R6 same-cycle raises line", int'(irq), 'b0010);
        issue(1, 2, 0);
        check("R6 same-cycle raises mask", rb(1), 'b1001);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_raise();
        t_self();
        t_merge();
        t_repeat();
        t_hold();
        t_arb();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule